// File: doc/BRIEF.md
# Flag-Producing Shift and Arithmetic ALU

This block is the combinational arithmetic unit of a single-cycle RISC datapath. It takes two 32-bit operands and a 5-bit function code and returns one 32-bit result together with zero, negative, overflow and carry flags. It can add, subtract, apply a bitwise Boolean function, and shift. Shifts treat the second operand as the data and the low bits of the first operand as the distance. That means an instruction's shift amount field, or a register value, can be steered onto the first operand while the value to shift arrives on the second.

The function code has four control fields. A subtract bit picks the sign of the adder's second input. A two-bit Boolean field picks the logic function, and also the shift kind. A shift bit and a math bit pick which unit drives the result. The block also compares the operands. When the subtract bit is set it reports signed and unsigned less-than, both taken from the adder's flags, so set-on-less-than instructions need only a final zero-extend in the datapath.

Top module: `flag_alu`

## Requirements
- R1: Function code fields are fn[4] subtract, fn[3:2] Boolean select, fn[1] shift and fn[0] math. When fn[1]=1 the shifter drives the result, whatever fn[0] is. Otherwise, when fn[0]=1 the adder drives it. Otherwise the logic unit drives it.
- R2: With fn[1]=0, fn[0]=1 and fn[4]=0, result equals opa+opb modulo 2^32.
- R3: With fn[1]=0, fn[0]=1 and fn[4]=1, result equals opa-opb modulo 2^32.
- R4: With fn[1]=1, fn[3:2] picks the shift applied to opb. 00 and 01 give a logical left shift, 10 gives a logical right shift, and 11 gives an arithmetic right shift that copies opb[31].
- R5: The shift distance is opa[4:0]; opa[31:5] has no effect on a shift result.
- R6: With fn[1]=0 and fn[0]=0, fn[3:2] picks a bitwise function of opa and opb: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R7: For every function code, flag_z is 1 exactly when result is all zeros, and flag_n equals result[31].
- R8: For every function code, flag_c is the carry out of opa + (fn[4] ? ~opb : opb) + fn[4]. For a subtraction this means flag_c=1 exactly when opa >= opb unsigned, which is the no-borrow case.
- R9: For every function code, flag_v is 1 when that adder operation overflows as signed two's complement. This is the case when both adder inputs share a sign and the sum's sign differs from it.
- R10: When fn[4]=1, lt_signed equals signed opa<opb, formed as the difference's sign XOR flag_v. lt_unsigned equals unsigned opa<opb, formed as NOT flag_c. Both hold whatever fn[1:0] is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand; shift distance in bits 4:0 |
| opb | input | 32 | Second operand; data for shifts |
| fn | input | 5 | Function code {subtract, Boolean[1:0], shift, math} |
| result | output | 32 | Selected result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| flag_v | output | 1 | Signed overflow of the adder operation |
| flag_c | output | 1 | Carry out of the adder operation |
| lt_signed | output | 1 | Signed opa<opb (valid with subtract bit set) |
| lt_unsigned | output | 1 | Unsigned opa<opb (valid with subtract bit set) |

## Verification
The block holds no state, so a fault in a decode line or in a shifter stage shows on the result and flags the instant the inputs settle, in the same cycle the vector is applied. A broken stage in the logarithmic shifter only shows when that bit of the distance is set. Wrong fill only shows on right shifts of negative data. A swapped carry-in or overflow term only shows near the signed and unsigned wrap points. The directed vectors therefore hit shift distances 0, 31 and ones with high bits set, and also the most negative value, equal operands and all-ones. Random vectors cover the cross terms between these cases.

// File: rtl/flag_alu_pkg.sv
// Shared types for the flag-producing ALU.
// Assumes the function code layout {sub, bsel[1:0], shft, math}.
package flag_alu_pkg;

    // Decoded function code fields
    typedef struct packed {
        logic       sub;
        logic [1:0] bsel;
        logic       shft;
        logic       math;
    } alu_fn_t;

    // Bitwise function chosen by bsel when the logic unit drives the result
    typedef enum logic [1:0] {
        LOG_AND = 2'b00,
        LOG_OR  = 2'b01,
        LOG_XOR = 2'b10,
        LOG_NOR = 2'b11
    } logic_op_e;

    // Which unit drives the result
    typedef enum logic [1:0] {
        RES_LOGIC = 2'b00,
        RES_ARITH = 2'b01,
        RES_SHIFT = 2'b10
    } res_sel_e;

    // Shift has priority over math, math over logic
    function automatic res_sel_e pick_result(alu_fn_t f);
        if (f.shft)      return RES_SHIFT;
        else if (f.math) return RES_ARITH;
        else             return RES_LOGIC;
    endfunction

endpackage

// File: rtl/flag_alu_adder.sv
// Adder/subtractor with carry and signed-overflow outputs.
// Subtraction is a + ~b + 1, so carry=1 means no borrow.
module flag_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    // Invert the second input and inject a carry for subtraction
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[WIDTH-1:0];
        carry = wide[WIDTH];
        ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/flag_alu_shifter.sv
// Logarithmic barrel shifter: one right-shift core, with left shifts done by
// reversing the bits before and after it.
// Assumes WIDTH is a power of two and AMT_W = log2(WIDTH).
module flag_alu_shifter #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data,
    input  logic [AMT_W-1:0] amt,
    input  logic             to_right,
    input  logic             arith,
    output logic [WIDTH-1:0] out
);
    logic [WIDTH-1:0] data_rev;
    logic [WIDTH-1:0] core_rev;
    logic [WIDTH-1:0] stage [0:AMT_W];
    logic             fill;

    // Bit reversal of input and of core output
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign data_rev[i] = data[WIDTH-1-i];
        assign core_rev[i] = stage[AMT_W][WIDTH-1-i];
    end

    assign fill     = to_right & arith & data[WIDTH-1];
    assign stage[0] = to_right ? data : data_rev;

    // One stage per distance bit, each moving by a power of two
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
                                   : stage[k];
    end

    assign out = to_right ? stage[AMT_W] : core_rev;
endmodule

// File: rtl/flag_alu_logic.sv
// Bitwise Boolean unit: AND, OR, XOR or NOR of the two operands.
module flag_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]            a,
    input  logic [WIDTH-1:0]            b,
    input  flag_alu_pkg::logic_op_e     op,
    output logic [WIDTH-1:0]            out
);
    import flag_alu_pkg::*;

    // Select the bitwise function
    always_comb begin
        unique case (op)
            LOG_AND: out = a & b;
            LOG_OR:  out = a | b;
            LOG_XOR: out = a ^ b;
            LOG_NOR: out = ~(a | b);
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
// Top of the combinational ALU. Decodes the function code, steers one of the
// three units onto the result, and forms Z/N from the result and V/C plus the
// less-than outputs from the adder. The adder always runs, so V, C and the
// compares follow the subtract bit whatever unit drives the result.
module flag_alu #(
    parameter int WIDTH  = 32,
    parameter int FN_W   = 5,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_c,
    output logic             lt_signed,
    output logic             lt_unsigned
);
    import flag_alu_pkg::*;

    alu_fn_t          dec;
    res_sel_e         sel;
    logic [WIDTH-1:0] add_out;
    logic [WIDTH-1:0] shf_out;
    logic [WIDTH-1:0] log_out;
    logic             add_c;
    logic             add_v;

    // Split the code into its fields
    always_comb begin
        dec = alu_fn_t'(fn);
        sel = pick_result(dec);
    end

    flag_alu_adder #(.WIDTH(WIDTH)) u_add (
        .a     (opa),
        .b     (opb),
        .sub   (dec.sub),
        .sum   (add_out),
        .carry (add_c),
        .ovf   (add_v)
    );

    flag_alu_shifter #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shf (
        .data     (opb),
        .amt      (opa[AMT_W-1:0]),
        .to_right (dec.bsel[1]),
        .arith    (dec.bsel[0]),
        .out      (shf_out)
    );

    flag_alu_logic #(.WIDTH(WIDTH)) u_log (
        .a   (opa),
        .b   (opb),
        .op  (logic_op_e'(dec.bsel)),
        .out (log_out)
    );

    // Result select
    always_comb begin
        unique case (sel)
            RES_SHIFT: result = shf_out;
            RES_ARITH: result = add_out;
            default:   result = log_out;
        endcase
    end

    // Flags and comparisons
    always_comb begin
        flag_z      = ~|result;
        flag_n      = result[WIDTH-1];
        flag_v      = add_v;
        flag_c      = add_c;
        lt_signed   = add_out[WIDTH-1] ^ add_v;
        lt_unsigned = ~add_c;
    end
endmodule

// File: rtl/flag_alu_chk.sv
// Checker for flag_alu: immediate assertions comparing ports with plain
// operator results. The block has no clock, so every check is combinational.
module flag_alu_chk #(
    parameter int WIDTH  = 32,
    parameter int FN_W   = 5,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [FN_W-1:0]  fn,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_v,
    input logic             flag_c,
    input logic             lt_signed,
    input logic             lt_unsigned
);
    // Checks evaluated whenever inputs or outputs move
    always_comb begin
        if (fn[1:0] == 2'b01 && !fn[4])
            AST_ADD_SUM: assert (result == opa + opb) else $error("add mismatch"); // R2
        if (fn[1:0] == 2'b01 && fn[4])
            AST_SUB_DIFF: assert (result == opa - opb) else $error("sub mismatch"); // R3
        if (fn[1] && !fn[3])
            AST_SHIFT_LEFT: assert (result == (opb << opa[AMT_W-1:0])) else $error("sll mismatch"); // R4
        if (fn[1] && fn[3:2] == 2'b11)
            AST_SHIFT_ARITH: assert (result == $unsigned($signed(opb) >>> opa[AMT_W-1:0])) else $error("sra mismatch"); // R4
        if (fn[1:0] == 2'b00 && fn[3:2] == 2'b00)
            AST_AND_SIGN: assert (flag_n == (opa[WIDTH-1] & opb[WIDTH-1])) else $error("N mismatch"); // R7
        if (fn[1:0] == 2'b00 && fn[3:2] == 2'b10)
            AST_XOR_ZERO: assert (flag_z == (opa == opb)) else $error("Z mismatch"); // R7
        if (fn[4])
            AST_NO_BORROW: assert (flag_c == (opa >= opb)) else $error("C mismatch"); // R8
        if (fn[4] && opa == opb)
            AST_EQUAL_NO_OVERFLOW: assert (!flag_v) else $error("V on equal"); // R9
        if (fn[4])
            AST_LESS_UNSIGNED: assert (lt_unsigned == (opa < opb)) else $error("ltu mismatch"); // R10
        if (fn[4])
            AST_LESS_SIGNED: assert (lt_signed == ($signed(opa) < $signed(opb))) else $error("lts mismatch"); // R10
    end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH), .FN_W(FN_W)) u_chk (.*);

// File: tb/test_flag_alu.sv
// Self-checking bench: directed corner cases followed by seeded random
// vectors, each compared field by field against a bench-side model.
module test_flag_alu;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [4:0]    fn  = '0;
    logic [W-1:0]  result;
    logic          flag_z, flag_n, flag_v, flag_c, lt_signed, lt_unsigned;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    flag_alu i_flag_alu (
        .opa(opa), .opb(opb), .fn(fn), .result(result),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
        .lt_signed(lt_signed), .lt_unsigned(lt_unsigned)
    );

    // Reference result per the requirements
    function automatic logic [W-1:0] ref_result(logic [W-1:0] a, logic [W-1:0] b, logic [4:0] f);
        int sh = int'(a[4:0]);
        if (f[1]) begin
            case (f[3:2])
                2'b10:   return b >> sh;
                2'b11:   return $unsigned($signed(b) >>> sh);
                default: return b << sh;
            endcase
        end else if (f[0]) begin
            return f[4] ? a - b : a + b;
        end else begin
            case (f[3:2])
                2'b00:   return a & b;
                2'b01:   return a | b;
                2'b10:   return a ^ b;
                default: return ~(a | b);
            endcase
        end
    endfunction

    // Reference carry: subtraction means no borrow, addition means 33rd bit
    function automatic logic ref_carry(logic [W-1:0] a, logic [W-1:0] b, logic sub);
        logic [W:0] t;
        if (sub) return a >= b;
        t = {1'b0, a} + {1'b0, b};
        return t[W];
    endfunction

    // Reference overflow from exact signed arithmetic
    function automatic logic ref_ovf(logic [W-1:0] a, logic [W-1:0] b, logic sub);
        longint x = longint'($signed(a));
        longint y = longint'($signed(b));
        longint e = sub ? x - y : x + y;
        return (e > 64'sd2147483647) || (e < -64'sd2147483648);
    endfunction

    // Requirement tag for the result check of a given code
    function automatic string res_tag(logic [W-1:0] a, logic [4:0] f);
        if (f[1] && f[0])       return "R1";
        if (f[1] && a[31:5] != 0) return "R5";
        if (f[1])               return "R4";
        if (f[0])               return f[4] ? "R3" : "R2";
        return "R6";
    endfunction

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: opa=%h opb=%h fn=%b actual=%h expected=%h",
                     tag, what, opa, opb, fn, act, exp);
        end
    endtask

    // Apply one vector and compare every output
    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [4:0] f);
        logic [W-1:0] r;
        @(posedge clk);
        opa = a; opb = b; fn = f;
        @(negedge clk);
        r = ref_result(a, b, f);
        check(res_tag(a, f), "result", result, r);
        check("R7", "flag_z", {31'd0, flag_z}, {31'd0, r == '0});
        check("R7", "flag_n", {31'd0, flag_n}, {31'd0, r[W-1]});
        check("R8", "flag_c", {31'd0, flag_c}, {31'd0, ref_carry(a, b, f[4])});
        check("R9", "flag_v", {31'd0, flag_v}, {31'd0, ref_ovf(a, b, f[4])});
        if (f[4]) begin
            check("R10", "lt_signed", {31'd0, lt_signed}, {31'd0, $signed(a) < $signed(b)});
            check("R10", "lt_unsigned", {31'd0, lt_unsigned}, {31'd0, a < b});
        end
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7331);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero inputs give zero result with Z set (R7)
        @(negedge clk);
        check("R7", "reset result", result, '0);
        check("R7", "reset flag_z", {31'd0, flag_z}, 32'd1);

        // Directed corners
        apply(32'h0000_0000, 32'h0000_0000, 5'b00001);   // R2 zero
        apply(32'hFFFF_FFFF, 32'h0000_0001, 5'b00001);   // R2/R8 carry, Z
        apply(32'h7FFF_FFFF, 32'h0000_0001, 5'b00001);   // R9 positive overflow
        apply(32'h8000_0000, 32'h8000_0000, 5'b00001);   // R9 negative overflow
        apply(32'h1234_5678, 32'h1234_5678, 5'b10001);   // R3 equal
        apply(32'h0000_0000, 32'h0000_0001, 5'b10001);   // R3/R10 borrow
        apply(32'h8000_0000, 32'h0000_0001, 5'b10001);   // R9/R10 wrap
        apply(32'h0000_0000, 32'h8000_0000, 5'b10001);   // R9 sub most negative
        apply(32'h0000_0000, 32'h8000_0001, 5'b00010);   // R4 distance 0
        apply(32'h0000_001F, 32'h8000_0001, 5'b00010);   // R4 sll 31
        apply(32'h0000_001F, 32'h8000_0001, 5'b01010);   // R4 srl 31
        apply(32'h0000_001F, 32'h8000_0001, 5'b01110);   // R4 sra 31
        apply(32'h0000_0004, 32'hF000_0000, 5'b01110);   // R4 sra fill
        apply(32'hFFFF_FFE5, 32'h0000_00F0, 5'b00010);   // R5 high bits ignored
        apply(32'h0000_0025, 32'hC000_0000, 5'b01010);   // R5 distance 5
        apply(32'h0000_0003, 32'h0000_0011, 5'b00011);   // R1 shift beats math
        apply(32'h0000_0003, 32'h0000_0011, 5'b10111);   // R1/R10 shift with sub
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 5'b00000);   // R6 AND
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 5'b00100);   // R6 OR
        apply(32'hF0F0_F0F0, 32'hF0F0_F0F0, 5'b01000);   // R6 XOR equal -> Z
        apply(32'h0000_0000, 32'h0000_0000, 5'b01100);   // R6 NOR all ones
        apply(32'hFFFF_FFFF, 32'h0000_0000, 5'b11100);   // R10 with logic selected

        // Seeded random vectors
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a = $urandom;
            logic [W-1:0] b = $urandom;
            logic [4:0]   f = 5'($urandom);
            if (i % 4 == 0) a[31:5] = 27'($urandom) & {27{1'b1}};
            apply(a, b, f);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule